// File: doc/BRIEF.md
# Cell-Framed Queue Writer

This block is the write side of one input queue in a cell multiplexer. An upstream source delivers 9-bit bytes under a three-signal handshake: a cell-available flag, an enable strobe and a start-of-cell marker. The block stores only whole cells of a size chosen at reset in a 128-byte buffer. A downstream scheduler sees a cell-ready flag and drains bytes through a plain pop port. A cell becomes visible to the read side only when its final byte has been written.

The handshake has two directions, chosen by one mode input. In receive style the block drives the enable strobe, and a byte counts on the clock edge that follows an enabled cycle. In transmit style the sender drives the enable strobe and the byte counts on the same edge. In that mode the block drives cell-available to say that a further whole cell fits. Framing works off a byte counter inside the cell. A start marker counts only on the first byte of a cell. A short cell is filled out with bytes from the cell that follows it. Bytes past the end of a long cell are dropped until the next proper start.

Top module: `cellq_writer`

## Requirements
- R1: The cell size is taken from `size_code` on the first clock edge after reset is released and is then held until the next reset. A code of 0 selects 128 bytes, codes 1 to 7 are raised to 8, and codes 8 to 127 select that many bytes.
- R2: With `use_default` high at that edge, the size is 53 bytes whatever the code.
- R3: While no cell is in progress, a byte is accepted only when the strobe is active, `up_soc` is high and, in receive style, `up_cav` is high. Any other byte is discarded.
- R4: After the first byte of a cell, `up_soc` is ignored until the cell reaches its size. A short cell is therefore completed with the leading bytes of the next cell, and the rest of that next cell is discarded.
- R5: Once a cell reaches its size, further bytes are discarded until a new start is seen. This applies to the surplus bytes of a long cell.
- R6: Receive style (`mode_tx`=0): a byte is written on the edge that ends the cycle after a cycle with `up_en_out` high. Once a cell has started, `up_cav` falling low does not stop writes.
- R7: Receive style: `up_en_out` is low whenever the next byte would begin a cell that cannot fit in the free space. It rises again once reads free enough space.
- R8: Transmit style (`mode_tx`=1): a byte is written on the edge where `up_en_in` is high. `up_cav_out` is high only when one more whole cell fits beyond any cell in progress. A start presented when no cell fits is discarded.
- R9: `cell_rdy` is high while at least one committed cell has bytes not yet read, and it stays high until the last byte of that cell is read. A cell still being written is neither ready nor readable.
- R10: `rd_valid` is high when committed bytes remain, and `rd_data` shows the oldest of them. `rd_en` together with `rd_valid` removes that byte. Bytes leave in the order they were written.
- R11: The number of stored bytes, committed and in progress together, never exceeds 128.
- R12: `up_cav_out` is low in receive style and `up_en_out` is low in transmit style. Both are low during reset and in the configuration cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_tx | input | 1 | 0 = receive style (block drives enable), 1 = transmit style (sender drives enable) |
| size_code | input | 7 | Cell size code, sampled on the first edge after reset |
| use_default | input | 1 | Selects the 53-byte default size instead of the code |
| up_data | input | 9 | Incoming byte |
| up_soc | input | 1 | Start-of-cell marker for the first byte |
| up_cav | input | 1 | Upstream cell available (receive style) |
| up_en_in | input | 1 | Sender's enable strobe (transmit style) |
| up_en_out | output | 1 | Block's enable strobe to the sender (receive style) |
| up_cav_out | output | 1 | Room for one more whole cell (transmit style) |
| rd_en | input | 1 | Pop request from the scheduler |
| rd_data | output | 9 | Oldest committed byte |
| rd_valid | output | 1 | Committed bytes are available |
| cell_rdy | output | 1 | At least one complete cell is stored |

## Verification
On every cycle the assertions check these properties: the buffer is never overfilled, the in-cell count stays below the size, the size stays fixed after configuration, each handshake output is silent in the mode it does not belong to, and in receive style every write is preceded by an enabled cycle. They also check that cell-ready agrees with read availability and rises only on a cell's final byte. Only the bench's scenarios can show what is actually stored in the buffer. That covers realignment after short and long cells, discarding of bytes that arrive without a start or without room, and the pause and resume of the enable strobe, all seen through the byte order popped at the read port. Those scenarios also cover the decoding of size codes and the default size.

// File: rtl/cellq_pkg.sv
package cellq_pkg;
  localparam int DEF_CELL = 53;
  localparam int MIN_CELL = 8;

  typedef enum logic {
    SIG_RX = 1'b0,
    SIG_TX = 1'b1
  } sig_mode_e;
endpackage

// File: rtl/cellq_size_cfg.sv
module cellq_size_cfg
  import cellq_pkg::*;
#(
  parameter int CODEW = 7,
  parameter int CW    = 8,
  parameter int DEPTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CODEW-1:0] size_code,
  input  logic             use_default,
  output logic [CW-1:0]    size_q,
  output logic             cfg_pend
);
  logic [CW-1:0] size_n;

  always_comb begin
    if (use_default)                          size_n = CW'(DEF_CELL);
    else if (size_code == '0)                 size_n = CW'(DEPTH);
    else if (size_code < CODEW'(MIN_CELL))    size_n = CW'(MIN_CELL);
    else                                      size_n = CW'(size_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_pend <= 1'b1;
      size_q   <= CW'(DEF_CELL);
    end else if (cfg_pend) begin
      cfg_pend <= 1'b0;
      size_q   <= size_n;
    end
  end
endmodule

// File: rtl/cellq_frame_ctl.sv
module cellq_frame_ctl
  import cellq_pkg::*;
#(
  parameter int CW    = 8,
  parameter int DEPTH = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sig_mode_e     sig_mode,
  input  logic          cfg_pend,
  input  logic [CW-1:0] size_q,
  input  logic [CW-1:0] commit_cnt,
  input  logic          in_cav,
  input  logic          in_en,
  input  logic          in_soc,
  output logic          en_out,
  output logic          cav_out,
  output logic          wr_we,
  output logic          wr_last,
  output logic [CW-1:0] part_cnt
);
  localparam int OW = CW + 1;

  logic          mid_q, mid_n, en_q, en_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [OW-1:0] avail, need1, need2;
  logic          fit1, fit2, strobe, start_ok, at_tail;

  always_comb begin
    avail    = OW'(DEPTH) - {1'b0, commit_cnt};
    need1    = {1'b0, size_q};
    need2    = {size_q, 1'b0};
    fit1     = avail >= need1;
    fit2     = avail >= need2;
    strobe   = (sig_mode == SIG_TX) ? in_en : en_q;
    start_ok = !cfg_pend && !mid_q && strobe && in_soc &&
               ((sig_mode == SIG_TX) || in_cav) && fit1;
    wr_we    = (mid_q && strobe) || start_ok;
    wr_last  = wr_we && ((cnt_q + CW'(1)) == size_q);
    // the byte in flight now closes the cell, so the next one opens a new cell
    at_tail  = en_q && (cnt_q == (size_q - CW'(1)));
    en_out   = !cfg_pend && (sig_mode == SIG_RX) && (mid_q ? (!at_tail || fit2) : fit1);
    cav_out  = !cfg_pend && (sig_mode == SIG_TX) && (mid_q ? fit2 : fit1);
    en_n     = en_out;
    mid_n    = mid_q;
    cnt_n    = cnt_q;
    if (wr_we) begin
      if (wr_last) begin
        mid_n = 1'b0;
        cnt_n = '0;
      end else begin
        mid_n = 1'b1;
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= 1'b0;
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= en_n;
      if (wr_we) begin
        mid_q <= mid_n;
        cnt_q <= cnt_n;
      end
    end
  end

  assign part_cnt = cnt_q;
endmodule

// File: rtl/cellq_store.sv
module cellq_store #(
  parameter int DW    = 9,
  parameter int CW    = 8,
  parameter int DEPTH = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_we,
  input  logic          wr_last,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] size_q,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          cell_rdy,
  output logic [CW-1:0] commit_cnt
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] commit_q, commit_n, cells_q, cells_n, rpos_q, rpos_n;
  logic          pop, pop_last;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    rd_valid = commit_q != '0;
    pop      = rd_en && rd_valid;
    pop_last = pop && (rpos_q == (size_q - CW'(1)));
    wp_n     = wr_we ? step(wp_q) : wp_q;
    rp_n     = pop ? step(rp_q) : rp_q;
    commit_n = commit_q + (wr_last ? size_q : '0) - (pop ? CW'(1) : '0);
    cells_n  = cells_q + CW'(wr_last) - CW'(pop_last);
    rpos_n   = pop ? (pop_last ? '0 : rpos_q + CW'(1)) : rpos_q;
  end

  always_ff @(posedge clk) begin
    if (wr_we) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q     <= '0;
      rp_q     <= '0;
      commit_q <= '0;
      cells_q  <= '0;
      rpos_q   <= '0;
    end else begin
      if (wr_we) wp_q <= wp_n;
      if (pop) begin
        rp_q   <= rp_n;
        rpos_q <= rpos_n;
      end
      if (wr_last || pop) begin
        commit_q <= commit_n;
        cells_q  <= cells_n;
      end
    end
  end

  assign rd_data    = mem[rp_q];
  assign cell_rdy   = cells_q != '0;
  assign commit_cnt = commit_q;
endmodule

// File: rtl/cellq_writer.sv
module cellq_writer
  import cellq_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_tx,
  input  logic [$clog2(DEPTH)-1:0]   size_code,
  input  logic                       use_default,
  input  logic [DW-1:0]              up_data,
  input  logic                       up_soc,
  input  logic                       up_cav,
  input  logic                       up_en_in,
  output logic                       up_en_out,
  output logic                       up_cav_out,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic                       rd_valid,
  output logic                       cell_rdy
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  sig_mode_e     sig_mode;
  logic [CW-1:0] size_q, commit_cnt, part_cnt;
  logic          cfg_pend, wr_we, wr_last;

  assign sig_mode = sig_mode_e'(mode_tx);

  cellq_size_cfg #(.CODEW(AW), .CW(CW), .DEPTH(DEPTH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .size_code(size_code), .use_default(use_default),
    .size_q(size_q), .cfg_pend(cfg_pend)
  );

  cellq_frame_ctl #(.CW(CW), .DEPTH(DEPTH)) u_frame (
    .clk(clk), .rst_n(rst_n), .sig_mode(sig_mode), .cfg_pend(cfg_pend),
    .size_q(size_q), .commit_cnt(commit_cnt), .in_cav(up_cav), .in_en(up_en_in),
    .in_soc(up_soc), .en_out(up_en_out), .cav_out(up_cav_out), .wr_we(wr_we),
    .wr_last(wr_last), .part_cnt(part_cnt)
  );

  cellq_store #(.DW(DW), .CW(CW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_we(wr_we), .wr_last(wr_last), .wr_data(up_data),
    .size_q(size_q), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .cell_rdy(cell_rdy), .commit_cnt(commit_cnt)
  );
endmodule

// File: rtl/cellq_writer_chk.sv
module cellq_writer_chk #(
  parameter int CW    = 8,
  parameter int DEPTH = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_tx,
  input logic          up_en_out,
  input logic          up_cav_out,
  input logic          cell_rdy,
  input logic          rd_valid,
  input logic          wr_we,
  input logic          wr_last,
  input logic          cfg_pend,
  input logic [CW-1:0] commit_cnt,
  input logic [CW-1:0] part_cnt,
  input logic [CW-1:0] size_q
);
  localparam int OW = CW + 1;

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, commit_cnt} + {1'b0, part_cnt}) <= OW'(DEPTH));

  a_r4_count_below_size: assert property (@(posedge clk) disable iff (!rst_n)
    part_cnt < size_q);

  a_r1_size_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pend && !$past(cfg_pend)) |-> $stable(size_q));

  a_r12_rx_no_cav_out: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_tx |-> !up_cav_out);

  a_r12_tx_no_en_out: assert property (@(posedge clk) disable iff (!rst_n)
    mode_tx |-> !up_en_out);

  a_r6_rx_write_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_tx && $past(!mode_tx) && wr_we) |-> $past(up_en_out));

  a_r9_ready_matches_readable: assert property (@(posedge clk) disable iff (!rst_n)
    cell_rdy == rd_valid);

  a_r9_ready_rises_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cell_rdy) |-> $past(wr_last));
endmodule

bind cellq_writer cellq_writer_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .up_en_out(up_en_out),
  .up_cav_out(up_cav_out), .cell_rdy(cell_rdy), .rd_valid(rd_valid),
  .wr_we(wr_we), .wr_last(wr_last), .cfg_pend(cfg_pend),
  .commit_cnt(commit_cnt), .part_cnt(part_cnt), .size_q(size_q)
);

// File: tb/cellq_writer_test.sv
module cellq_writer_test;
  localparam int DW = 9;
  localparam int DEPTH = 128;
  // each entry: {size code[6:0], use_default, expected cell size[7:0]}
  localparam logic [15:0] VEC [6] = '{
    {7'd0,  1'b0, 8'd128},
    {7'd10, 1'b0, 8'd10},
    {7'd5,  1'b0, 8'd8},
    {7'd99, 1'b1, 8'd53},
    {7'd8,  1'b0, 8'd8},
    {7'd64, 1'b0, 8'd64}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, mode_tx, use_default, up_soc, up_cav, up_en_in, rd_en;
  logic [6:0]    size_code;
  logic [DW-1:0] up_data, rd_data;
  logic          up_en_out, up_cav_out, rd_valid, cell_rdy;

  cellq_writer uut (
    .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .size_code(size_code),
    .use_default(use_default), .up_data(up_data), .up_soc(up_soc), .up_cav(up_cav),
    .up_en_in(up_en_in), .up_en_out(up_en_out), .up_cav_out(up_cav_out),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .cell_rdy(cell_rdy)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit last_en = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one cycle; wr_ok tells whether the byte now driven is taken in receive style
  task automatic tick(output bit wr_ok);
    wr_ok = last_en;
    last_en = up_en_out;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    bit o;
    repeat (n) tick(o);
  endtask

  task automatic do_reset(input bit tx, input logic [6:0] code, input bit def);
    rst_n = 1'b0; mode_tx = tx; size_code = code; use_default = def;
    up_data = '0; up_soc = 1'b0; up_cav = 1'b0; up_en_in = 1'b0; rd_en = 1'b0;
    last_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic tx_push(input logic [DW-1:0] d, input bit s);
    up_data = d; up_soc = s; up_en_in = 1'b1;
    idle(1);
    up_en_in = 1'b0; up_soc = 1'b0;
  endtask

  task automatic rx_push(input logic [DW-1:0] d, input bit s, input bit c);
    bit ok;
    do begin
      up_data = d; up_soc = s; up_cav = c;
      tick(ok);
    end while (!ok);
    up_soc = 1'b0; up_cav = 1'b0;
  endtask

  task automatic pop_chk(input logic [DW-1:0] exp, input string tag);
    chk(rd_valid == 1'b1, tag, int'(rd_valid), 1);
    chk(rd_data == exp, tag, int'(rd_data), int'(exp));
    rd_en = 1'b1;
    idle(1);
    rd_en = 1'b0;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state (R12, R9, R10)
    rst_n = 1'b0; mode_tx = 1'b0; size_code = 7'd8; use_default = 1'b0;
    up_data = '0; up_soc = 1'b0; up_cav = 1'b0; up_en_in = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(cell_rdy == 1'b0, "R9 reset cell_rdy", int'(cell_rdy), 0);
    chk(rd_valid == 1'b0, "R10 reset rd_valid", int'(rd_valid), 0);
    chk(up_en_out == 1'b0 && up_cav_out == 1'b0, "R12 reset handshake",
        int'({up_en_out, up_cav_out}), 0);

    // table walk: size decode (R1, R2), transmit writes with pauses (R8), read order (R10)
    for (int v = 0; v < 6; v++) begin
      automatic int sz = int'(VEC[v][7:0]);
      do_reset(1'b1, VEC[v][15:9], VEC[v][8]);
      chk(up_cav_out == 1'b1, "R8 room when empty", int'(up_cav_out), 1);
      chk(up_en_out == 1'b0, "R12 tx en_out low", int'(up_en_out), 0);
      for (int k = 0; k < sz; k++) begin
        if (k == sz - 1)
          chk(cell_rdy == 1'b0 && rd_valid == 1'b0, "R9 partial cell hidden",
              int'({cell_rdy, rd_valid}), 0);
        tx_push(DW'((k * 7 + v) & 9'h1ff), k == 0);
        if (k % 3 == 2) idle(1);
      end
      chk(cell_rdy == 1'b1, "R1 R2 cell complete at size", int'(cell_rdy), 1);
      for (int k = 0; k < sz; k++) begin
        chk(cell_rdy == 1'b1, "R9 ready until drained", int'(cell_rdy), 1);
        pop_chk(DW'((k * 7 + v) & 9'h1ff), "R10 read order");
      end
      chk(rd_valid == 1'b0 && cell_rdy == 1'b0, "R1 R2 no extra bytes",
          int'({rd_valid, cell_rdy}), 0);
    end

    // short cell then realignment (R4), transmit style, size 8
    do_reset(1'b1, 7'd8, 1'b0);
    for (int k = 0; k < 5; k++) tx_push(DW'(9'h0a0 + k), k == 0);
    for (int k = 0; k < 8; k++) tx_push(DW'(9'h0b0 + k), k == 0);
    for (int k = 0; k < 8; k++) tx_push(DW'(9'h0c0 + k), k == 0);
    chk(cell_rdy == 1'b1, "R4 short cell filled", int'(cell_rdy), 1);
    for (int k = 0; k < 5; k++) pop_chk(DW'(9'h0a0 + k), "R4 short head");
    for (int k = 0; k < 3; k++) pop_chk(DW'(9'h0b0 + k), "R4 filler from next cell");
    for (int k = 0; k < 8; k++) pop_chk(DW'(9'h0c0 + k), "R4 third cell aligned");
    chk(rd_valid == 1'b0, "R4 surplus discarded", int'(rd_valid), 0);

    // stray bytes without start (R3), then long cell (R5)
    do_reset(1'b1, 7'd8, 1'b0);
    for (int k = 0; k < 3; k++) tx_push(9'h055, 1'b0);
    chk(rd_valid == 1'b0 && cell_rdy == 1'b0, "R3 no start no write",
        int'({rd_valid, cell_rdy}), 0);
    for (int k = 0; k < 11; k++) tx_push(DW'(9'h1a0 + k), k == 0);
    for (int k = 0; k < 8; k++) tx_push(DW'(9'h120 + k), k == 0);
    for (int k = 0; k < 8; k++) pop_chk(DW'(9'h1a0 + k), "R5 long cell head");
    for (int k = 0; k < 8; k++) pop_chk(DW'(9'h120 + k), "R5 next cell intact");
    chk(rd_valid == 1'b0, "R5 tail dropped", int'(rd_valid), 0);

    // transmit room and full buffer (R8, R11), size 64
    do_reset(1'b1, 7'd64, 1'b0);
    for (int k = 0; k < 64; k++) tx_push(DW'(9'h100 + k), k == 0);
    chk(up_cav_out == 1'b1, "R8 room for second cell", int'(up_cav_out), 1);
    tx_push(9'h180, 1'b1);
    chk(up_cav_out == 1'b0, "R8 no room for third cell", int'(up_cav_out), 0);
    for (int k = 1; k < 64; k++) tx_push(DW'(9'h180 + k), 1'b0);
    for (int k = 0; k < 8; k++) tx_push(9'h1ff, k == 0);
    for (int k = 0; k < 64; k++) pop_chk(DW'(9'h100 + k), "R11 first cell");
    chk(up_cav_out == 1'b1, "R8 room back after read", int'(up_cav_out), 1);
    for (int k = 0; k < 64; k++) pop_chk(DW'(9'h180 + k), "R11 second cell");
    chk(rd_valid == 1'b0, "R8 start without room dropped", int'(rd_valid), 0);

    // receive style basics (R6, R3, R4, R12), size 8
    do_reset(1'b0, 7'd8, 1'b0);
    chk(up_en_out == 1'b1, "R6 enable offered when empty", int'(up_en_out), 1);
    chk(up_cav_out == 1'b0, "R12 rx cav_out low", int'(up_cav_out), 0);
    rx_push(9'h077, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) rx_push(DW'(9'h0d0 + k), k == 0 || k == 4, k == 0);
    chk(cell_rdy == 1'b1, "R6 cell written though cav fell", int'(cell_rdy), 1);
    for (int k = 0; k < 8; k++) pop_chk(DW'(9'h0d0 + k), "R6 rx data");
    chk(rd_valid == 1'b0, "R3 start without cav dropped", int'(rd_valid), 0);

    // receive style pause and resume (R7), size 64
    do_reset(1'b0, 7'd64, 1'b0);
    for (int k = 0; k < 64; k++) rx_push(DW'(9'h140 + k), k == 0, 1'b1);
    for (int k = 0; k < 64; k++) rx_push(DW'(9'h1c0 + k), k == 0, 1'b1);
    up_data = 9'h1ee; up_soc = 1'b1; up_cav = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk(up_en_out == 1'b0, "R7 enable withheld when full", int'(up_en_out), 0);
      idle(1);
    end
    up_soc = 1'b0; up_cav = 1'b0;
    for (int k = 0; k < 64; k++) pop_chk(DW'(9'h140 + k), "R7 first cell");
    chk(up_en_out == 1'b1, "R7 enable resumes", int'(up_en_out), 1);
    for (int k = 0; k < 64; k++) pop_chk(DW'(9'h1c0 + k), "R7 second cell");
    chk(rd_valid == 1'b0, "R7 nothing written while withheld", int'(rd_valid), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule